// File: doc/BRIEF.md
# External Interrupt Edge Detector

The block watches a small set of external interrupt pins that share their package pads with general-purpose I/O. Each pin runs through a two-flop synchronizer. A held copy of the last synchronized value is compared with the current one to find rising and falling transitions. A programmable mode per pin picks which transitions count. A per-pin route-enable bit decides whether the pin feeds the interrupt function at all. A qualifying transition sets a sticky flag. Each clock is one machine cycle.

Software reaches three byte-wide registers through a simple write-strobe and address interface, with a combinational read path. Flags stay set until one of two things happens: an acknowledge pulse for that pin, or a software write of zero to that flag bit. A downstream interrupt controller sees the flags through a request output. That output is the flag vector registered once more, so a flag is seen one machine cycle after it is latched.

Top module: `ext_irq_edge`

## Requirements
- R1: While reset is asserted, and after it is released, the mode register, the route-enable register, all flags and all request outputs read zero.
- R2: Register map on `addr_i`. Address 0 is the mode register, all 8 bits read and write. Address 1 is route enable, with bits [3:0] one per pin and bits [7:4] reading zero. Address 2 is the flags in bits [3:0], with bits [7:4] reading zero. Address 3 reads zero. A write takes effect at the clock edge where `wr_en_i` is high.
- R3: Pin n uses mode bits [2n+1:2n]. The codes are 00 (no detection), 01 (falling), 10 (rising) and 11 (both). Writing 8'h11 selects falling detection on pins 0 and 2 and disables pins 1 and 3. In a falling-only mode a rising transition sets no flag.
- R4: A pin whose route-enable bit is 0 never sets its flag, whatever its mode and pin activity.
- R5: A level change applied to a pin before rising clock edge k sets the flag at edge k+2 when the mode and route enable qualify it. At edge k+1 the flag is still clear.
- R6: `irq_req_o` equals the flag vector as it was one clock earlier.
- R7: A flag stays set until cleared. It is cleared either by `ack_i` high for its pin or by a write to address 2 with that flag's bit equal to 0. Writing 1 to a flag bit leaves it unchanged.
- R8: When a qualifying transition and a clear for the same pin fall on the same clock edge, the flag ends set.
- R9: Changing a pin's mode or route-enable bit never creates a transition by itself. The sampled history of a pin keeps updating while the pin is disabled, so enabling it after the pin has changed level sets no flag.
- R10: In mode 11 both a rising and a falling transition set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one machine cycle per period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational on `addr_i` |
| ack_i | input | 4 | Per-pin flag clear pulse from the interrupt controller |
| irq_req_o | output | 4 | Per-pin interrupt request, flags delayed one cycle |

## Verification
The bound checker tests several properties on every clock. It checks that the request output follows the flags with a one-cycle lag. It checks that no flag rises on a disabled pin or without a detected transition. It checks that a flag only falls under an acknowledge or a write of zero, and that a detection always wins over a simultaneous clear. The bench covers what only scenarios can show: the exact three-edge latency from pin to flag, the mapping of mode codes to pin fields, and that a mode or route-enable change after a level change raises nothing. It also drives the register read-back values and the both-edges mode, comparing a behavioural model against the outputs every cycle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_ROUTE = 2'd1,
    REG_FLAG = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/eirq_edge_det.sv
module eirq_edge_det
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  localparam int unsigned SEL_W   = NUM_PINS * MODE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] smp_i,
  input  logic [SEL_W-1:0]    mode_i,
  input  logic [NUM_PINS-1:0] route_i,
  output logic [NUM_PINS-1:0] hit_o
);

  // history keeps tracking regardless of mode/route so enabling never fakes an edge
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= smp_i;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    edge_mode_e mode;
    logic       rise, fall, match;

    assign mode = edge_mode_e'(mode_i[MODE_W*g +: MODE_W]);
    assign rise = smp_i[g] & ~prev_q[g];
    assign fall = ~smp_i[g] & prev_q[g];

    always_comb begin
      unique case (mode)
        EDGE_FALL: match = fall;
        EDGE_RISE: match = rise;
        EDGE_BOTH: match = rise | fall;
        default:   match = 1'b0;
      endcase
    end

    assign hit_o[g] = route_i[g] & match;
  end

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 2,
  localparam int unsigned SEL_W   = NUM_PINS * MODE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] hit_i,
  input  logic [NUM_PINS-1:0] ack_i,
  output logic [SEL_W-1:0]    mode_o,
  output logic [NUM_PINS-1:0] route_o,
  output logic [NUM_PINS-1:0] flag_o,
  output logic [NUM_PINS-1:0] req_o
);

  logic [SEL_W-1:0]    mode_q;
  logic [NUM_PINS-1:0] route_q, flag_q, req_q, clr;
  logic                wr_mode, wr_route, wr_flag;

  assign wr_mode  = wr_en_i && (addr_i == ADDR_W'(REG_MODE));
  assign wr_route = wr_en_i && (addr_i == ADDR_W'(REG_ROUTE));
  assign wr_flag  = wr_en_i && (addr_i == ADDR_W'(REG_FLAG));

  assign clr = ack_i | (wr_flag ? ~wdata_i[NUM_PINS-1:0] : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      route_q <= '0;
    end else begin
      if (wr_mode)  mode_q  <= wdata_i[SEL_W-1:0];
      if (wr_route) route_q <= wdata_i[NUM_PINS-1:0];
    end
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      req_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | hit_i;
      req_q  <= flag_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(REG_MODE):  rdata_o[SEL_W-1:0]    = mode_q;
      ADDR_W'(REG_ROUTE): rdata_o[NUM_PINS-1:0] = route_q;
      ADDR_W'(REG_FLAG):  rdata_o[NUM_PINS-1:0] = flag_q;
      default:            rdata_o = '0;
    endcase
  end

  assign mode_o  = mode_q;
  assign route_o = route_q;
  assign flag_o  = flag_q;
  assign req_o   = req_q;

endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] ack_i,
  output logic [NUM_PINS-1:0] irq_req_o
);

  localparam int unsigned SEL_W = NUM_PINS * MODE_W;

  logic [NUM_PINS-1:0] smp, hit, route, flag;
  logic [SEL_W-1:0]    mode;

  eirq_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_i),
    .sync_o (smp)
  );

  eirq_edge_det #(
    .NUM_PINS(NUM_PINS)
  ) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (smp),
    .mode_i (mode),
    .route_i(route),
    .hit_o  (hit)
  );

  eirq_regs #(
    .NUM_PINS(NUM_PINS),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .hit_i  (hit),
    .ack_i  (ack_i),
    .mode_o (mode),
    .route_o(route),
    .flag_o (flag),
    .req_o  (irq_req_o)
  );

endmodule

// File: rtl/ext_irq_edge_chk.sv
module ext_irq_edge_chk #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [NUM_PINS-1:0] ack_i,
  input logic [NUM_PINS-1:0] hit,
  input logic [NUM_PINS-1:0] route,
  input logic [NUM_PINS-1:0] flag,
  input logic [NUM_PINS-1:0] req
);

  logic [NUM_PINS-1:0] clr_m;
  assign clr_m = ack_i | ((wr_en_i && addr_i == ADDR_W'(2)) ? ~wdata_i[NUM_PINS-1:0] : '0);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (flag == '0 && req == '0));

  assert_req_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req == $past(flag));

  assert_route_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag & ~$past(flag)) & ~$past(route)) == '0);

  assert_no_spurious_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag & ~$past(flag)) & ~$past(hit)) == '0);

  assert_sticky_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flag) & ~flag) & ~$past(clr_m)) == '0);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hit) & ~flag) == '0);

endmodule

bind ext_irq_edge ext_irq_edge_chk #(
  .NUM_PINS(NUM_PINS),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .ack_i  (ack_i),
  .hit    (hit),
  .route  (route),
  .flag   (flag),
  .req    (irq_req_o)
);

// File: tb/ext_irq_edge_tb_top.sv
module ext_irq_edge_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin = '0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd2;
  logic [7:0] wdata = '0;
  logic [3:0] ack = '0;
  logic [7:0] rdata;
  logic [3:0] req;

  int    vectors = 0;
  int    errors = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  ext_irq_edge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack), .irq_req_o(req)
  );

  // behavioural reference: history of pin samples, one per edge
  logic [3:0] hist [$];
  logic [7:0] m_mode;
  logic [3:0] m_route, m_flag, m_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{4'h0, 4'h0, 4'h0};
      m_mode = '0; m_route = '0; m_flag = '0; m_req = '0;
    end else begin
      logic [3:0] now_s, old_s, hitv, clrv;
      now_s = hist[1];
      old_s = hist[2];
      hitv = '0;
      for (int i = 0; i < 4; i++) begin
        int md;
        bit r, f;
        md = int'(m_mode[2*i +: 2]);
        r = now_s[i] && !old_s[i];
        f = !now_s[i] && old_s[i];
        if (m_route[i] && ((md == 1 && f) || (md == 2 && r) || (md == 3 && (r || f))))
          hitv[i] = 1'b1;
      end
      clrv = ack;
      if (wr_en && addr == 2'd2) clrv = clrv | ~wdata[3:0];
      m_req = m_flag;
      m_flag = (m_flag & ~clrv) | hitv;
      if (wr_en && addr == 2'd0) m_mode = wdata;
      if (wr_en && addr == 2'd1) m_route = wdata[3:0];
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_mode;
      2'd1: return {4'h0, m_route};
      2'd2: return {4'h0, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    #8;
    if (rst_n) begin
      vectors++;
      if (req !== m_req) begin
        errors++;
        $display("FAIL R6 cycle compare: irq_req_o=%h expected %h", req, m_req);
      end
      if (rdata !== m_read(addr)) begin
        errors++;
        $display("FAIL %s cycle compare: rdata_o=%h expected %h (addr %0d)", tag, rdata, m_read(addr), addr);
      end
    end
  end

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd2;
  endtask

  task automatic rd(input string t, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #2;
    check(t, rdata, exp);
    @(negedge clk);
    addr = 2'd2;
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    pin[i] = v;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    addr = 2'd2; #2;
    check("R1 flags in reset", rdata, 8'h00);
    check("R1 req in reset", {4'h0, req}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1 mode after reset", 2'd0, 8'h00);
    rd("R1 route after reset", 2'd1, 8'h00);
    rd("R1 flags after reset", 2'd2, 8'h00);

    // R2/R3: map and field layout
    tag = "R2";
    wr(2'd0, 8'h11);
    rd("R3 mode readback", 2'd0, 8'h11);
    wr(2'd1, 8'hFF);
    rd("R2 route upper bits zero", 2'd1, 8'h0F);
    rd("R2 unused address", 2'd3, 8'h00);
    wr(2'd1, 8'h05);

    // R3: rising edge in falling mode ignored
    tag = "R3";
    @(negedge clk); pin[0] = 1'b1; pin[2] = 1'b1;
    idle(5);
    rd("R3 rise ignored in falling mode", 2'd2, 8'h00);

    // R5/R6: latency of a falling edge on pin 0
    tag = "R5";
    set_pin(0, 1'b0);
    @(posedge clk); @(posedge clk); #5;
    check("R5 flag clear at edge k+1", {4'h0, dut_i.rdata_o[3:0]}, 8'h00);
    @(posedge clk); #5;
    check("R5 flag set at edge k+2", rdata, 8'h01);
    check("R6 req still low", {4'h0, req}, 8'h00);
    @(posedge clk); #5;
    check("R6 req one cycle later", {4'h0, req}, 8'h01);
    set_pin(2, 1'b0);
    idle(5);
    rd("R3 pin 2 falling", 2'd2, 8'h05);

    // R7: clears
    tag = "R7";
    wr(2'd2, 8'hFE);
    rd("R7 write zero clears bit 0 only", 2'd2, 8'h04);
    wr(2'd2, 8'hFF);
    rd("R7 write one no effect", 2'd2, 8'h04);
    @(negedge clk); ack = 4'b0100;
    @(negedge clk); ack = '0;
    rd("R7 ack clears", 2'd2, 8'h00);

    // R10: pin1 rising, pin3 both
    tag = "R10";
    wr(2'd0, 8'b11_00_10_01);
    wr(2'd1, 8'h0F);
    set_pin(1, 1'b1); set_pin(3, 1'b1);
    idle(5);
    rd("R3 pin1 rise, R10 pin3 rise", 2'd2, 8'h0A);
    wr(2'd2, 8'h00);
    set_pin(3, 1'b0); set_pin(1, 1'b0);
    idle(5);
    rd("R10 pin3 fall, R3 pin1 fall ignored", 2'd2, 8'h08);
    wr(2'd2, 8'h00);

    // R4: route disabled
    tag = "R4";
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    for (int i = 0; i < 4; i++) begin set_pin(i, 1'b1); idle(3); set_pin(i, 1'b0); end
    idle(5);
    rd("R4 no flag while disabled", 2'd2, 8'h00);

    // R9: enable and mode change after level change
    tag = "R9";
    set_pin(1, 1'b1);
    idle(6);
    wr(2'd1, 8'h02);
    idle(6);
    rd("R9 route enable makes no edge", 2'd2, 8'h00);
    wr(2'd0, 8'h00);
    set_pin(3, 1'b1);
    wr(2'd1, 8'h0A);
    idle(6);
    wr(2'd0, 8'b10_00_00_00);
    idle(6);
    rd("R9 mode change makes no edge", 2'd2, 8'h00);

    // R8: detection coincides with clearing write
    tag = "R8";
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h01);
    set_pin(0, 1'b1);
    idle(5);
    set_pin(0, 1'b0);
    @(negedge clk);
    wr(2'd2, 8'h00);
    rd("R8 set wins over clear", 2'd2, 8'h01);
    idle(3);

    finish_run();
  end

endmodule